// File: doc/BRIEF.md
# Accumulator Readout Rounding Formatter

This block is the register-side port of a multiply-accumulate unit's accumulator bank. It holds a small set of 48-bit accumulators, each with a sticky overflow bit. A read request selects one accumulator and a conversion mode, and one cycle later the block presents a 32-bit register word. In fractional mode the word is a rounded and optionally clamped 16-bit or 32-bit value. In signed or unsigned integer mode the word is a 32-bit value clamped to the limits of that type.

A write request loads one accumulator from a 32-bit register word. A fractional write places the value with eight guard bits below it. An integer write extends the value as signed or unsigned. Every write clears that accumulator's sticky overflow bit. The arithmetic datapath that sets the overflow bits lies outside this block and reaches it through a per-accumulator set input.

Top module: `acc_readout`

## Requirements
- R1: After reset every accumulator is zero, every sticky overflow bit is clear, `rd_valid_o` is 0 and `rd_data_o` is 0.
- R2: `rd_valid_o` is high exactly in the cycle after a cycle with `rd_req_i` high. `rd_data_o` changes only on the clock edge that samples a read request, and otherwise holds its value.
- R3: A fractional read with `rd_half_i`=1 takes accumulator bits 47..24 as a signed value and always rounds it using bits 23..0. A remainder above 0x800000 adds one. A remainder of exactly 0x800000 adds the value's bit 0. The low 16 bits go to `rd_data_o[15:0]`, and `rd_data_o[31:16]` is 0.
- R4: A fractional read with `rd_half_i`=0 and `rd_rnd_i`=1 takes bits 47..8 as a signed value and rounds it using bits 7..0. A remainder above 0x80 adds one. A remainder of exactly 0x80 adds the value's bit 0. The result is the low 32 bits.
- R5: A fractional read with `rd_half_i`=0 and `rd_rnd_i`=0 returns bits 39..8 of the accumulator unchanged.
- R6: In fractional mode with `rd_sat_i`=1, a rounded value outside the signed output range is clamped by its sign: to 0x7FFF or 0x8000 for 16-bit output, and to 0x7FFFFFFF or 0x80000000 for 32-bit output. With `rd_sat_i`=0 the value is truncated to the output width.
- R7: A signed integer read (`rd_frac_i`=0, `rd_uns_i`=0) returns bits 31..0 when the accumulator lies in the signed 32-bit range. Otherwise it returns 0x7FFFFFFF for a positive accumulator and 0x80000000 for a negative one.
- R8: An unsigned integer read (`rd_frac_i`=0, `rd_uns_i`=1) returns bits 31..0 when bits 47..32 are all zero, and 0xFFFFFFFF otherwise.
- R9: A fractional write (`wr_frac_i`=1) loads the sign-extended data word shifted left by 8.
- R10: An integer write loads the data word sign-extended when `wr_uns_i`=0 and zero-extended when `wr_uns_i`=1.
- R11: Bit i of `ovf_o` is set on the edge after `ovf_set_i[i]` is high. It stays set until a write to accumulator i, which clears it on that edge. A write clear has priority over a set in the same cycle.
- R12: A read and a write in the same cycle to the same accumulator return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request |
| rd_idx_i | input | IDX_W | Accumulator selected for reading |
| rd_frac_i | input | 1 | 1: fractional conversion; 0: integer |
| rd_uns_i | input | 1 | Integer conversion is unsigned (ignored when fractional) |
| rd_half_i | input | 1 | Fractional 16-bit output |
| rd_rnd_i | input | 1 | Round a 32-bit fractional output |
| rd_sat_i | input | 1 | Clamp a fractional output that overflows |
| rd_data_o | output | DATA_W | Converted read word |
| rd_valid_o | output | 1 | Read word valid |
| wr_req_i | input | 1 | Write request |
| wr_idx_i | input | IDX_W | Accumulator selected for writing |
| wr_frac_i | input | 1 | Fractional write alignment |
| wr_uns_i | input | 1 | Integer write is zero-extended |
| wr_data_i | input | DATA_W | Write data word |
| ovf_set_i | input | NUM_ACC | Per-accumulator overflow set strobes |
| ovf_o | output | NUM_ACC | Sticky overflow bits |

## Verification
A read's converted word and `rd_valid_o` are due on the first rising edge after the request. A write's new accumulator value becomes visible to a read issued on the following cycle. Overflow set and clear appear on `ovf_o` one edge after the strobe. The bench drives inputs on the falling edge and advances its model on the rising edge, reading the accumulator before any same-cycle write. It compares valid, data and overflow bits on every falling edge, so each result is checked in exactly the cycle it is due and the held value is checked in every other cycle.

// File: rtl/acc_readout_pkg.sv
package acc_readout_pkg;
  typedef struct packed {
    logic frac;
    logic uns;
    logic half;
    logic rnd;
    logic sat;
  } rd_mode_t;
endpackage

// File: rtl/acc_rounder.sv
// Arithmetic shift by SH, optional round-half-even, optional signed clamp to OUT_W.
module acc_rounder #(
  parameter int IN_W  = 48,
  parameter int SH    = 8,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  acc_i,
  input  logic             rnd_i,
  input  logic             sat_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int Q_W = IN_W - SH;
  localparam int R_W = Q_W + 1;
  localparam logic [SH-1:0] HALF_V = {1'b1, {(SH-1){1'b0}}};

  logic [Q_W-1:0]   q;
  logic [SH-1:0]    rem;
  logic             inc;
  logic [R_W-1:0]   r;
  logic [R_W-OUT_W:0] top;
  logic             fits;

  assign q    = acc_i[IN_W-1:SH];
  assign rem  = acc_i[SH-1:0];
  assign inc  = rnd_i && ((rem > HALF_V) || ((rem == HALF_V) && q[0]));
  assign r    = {q[Q_W-1], q} + {{Q_W{1'b0}}, inc};
  assign top  = r[R_W-1:OUT_W-1];
  assign fits = (&top) || ~(|top);

  always_comb begin
    if (sat_i && !fits) val_o = {r[R_W-1], {(OUT_W-1){~r[R_W-1]}}};
    else                val_o = r[OUT_W-1:0];
  end
endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt
  import acc_readout_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  rd_mode_t          mode_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int HALF_SH = GUARD_W + HALF_W;

  logic [HALF_W-1:0] half_val;
  logic [DATA_W-1:0] full_val;
  logic [ACC_W-DATA_W:0] s_top;
  logic s_fits, u_fits;

  acc_rounder #(.IN_W(ACC_W), .SH(HALF_SH), .OUT_W(HALF_W)) u_half (
    .acc_i (acc_i),
    .rnd_i (1'b1),
    .sat_i (mode_i.sat),
    .val_o (half_val)
  );

  acc_rounder #(.IN_W(ACC_W), .SH(GUARD_W), .OUT_W(DATA_W)) u_full (
    .acc_i (acc_i),
    .rnd_i (mode_i.rnd),
    .sat_i (mode_i.sat),
    .val_o (full_val)
  );

  assign s_top  = acc_i[ACC_W-1:DATA_W-1];
  assign s_fits = (&s_top) || ~(|s_top);
  assign u_fits = ~(|acc_i[ACC_W-1:DATA_W]);

  always_comb begin
    if (mode_i.frac) begin
      data_o = mode_i.half ? {{(DATA_W-HALF_W){1'b0}}, half_val} : full_val;
    end else if (mode_i.uns) begin
      data_o = u_fits ? acc_i[DATA_W-1:0] : {DATA_W{1'b1}};
    end else begin
      data_o = s_fits ? acc_i[DATA_W-1:0]
                      : {acc_i[ACC_W-1], {(DATA_W-1){~acc_i[ACC_W-1]}}};
    end
  end
endmodule

// File: rtl/acc_readout_bank.sv
module acc_readout_bank #(
  parameter int NUM_ACC = 4,
  parameter int ACC_W   = 48,
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_req_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic                            wr_frac_i,
  input  logic                            wr_uns_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  input  logic [NUM_ACC-1:0]              ovf_set_i,
  output logic [NUM_ACC-1:0][ACC_W-1:0]   acc_o,
  output logic [NUM_ACC-1:0]              ovf_o
);
  localparam int EXT_W  = ACC_W - DATA_W;
  localparam int FEXT_W = ACC_W - DATA_W - GUARD_W;

  logic [ACC_W-1:0] wr_val;
  logic             sgn;

  assign sgn = wr_data_i[DATA_W-1];

  always_comb begin
    if (wr_frac_i)     wr_val = {{FEXT_W{sgn}}, wr_data_i, {GUARD_W{1'b0}}};
    else if (wr_uns_i) wr_val = {{EXT_W{1'b0}}, wr_data_i};
    else               wr_val = {{EXT_W{sgn}}, wr_data_i};
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic hit;
    assign hit = wr_req_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_o[g] <= '0;
        ovf_o[g] <= 1'b0;
      end else begin
        if (hit) acc_o[g] <= wr_val;
        // write clear wins over a same-cycle set
        ovf_o[g] <= (ovf_o[g] | ovf_set_i[g]) & ~hit;
      end
    end
  end
endmodule

// File: rtl/acc_readout.sv
module acc_readout
  import acc_readout_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int ACC_W   = 48,
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_req_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  input  logic               rd_frac_i,
  input  logic               rd_uns_i,
  input  logic               rd_half_i,
  input  logic               rd_rnd_i,
  input  logic               rd_sat_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_valid_o,
  input  logic               wr_req_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_frac_i,
  input  logic               wr_uns_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_ACC-1:0] ovf_set_i,
  output logic [NUM_ACC-1:0] ovf_o
);
  logic [NUM_ACC-1:0][ACC_W-1:0] acc;
  rd_mode_t                      mode;
  logic [DATA_W-1:0]             fmt_data;

  acc_readout_bank #(
    .NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .DATA_W(DATA_W), .GUARD_W(GUARD_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (wr_req_i),
    .wr_idx_i  (wr_idx_i),
    .wr_frac_i (wr_frac_i),
    .wr_uns_i  (wr_uns_i),
    .wr_data_i (wr_data_i),
    .ovf_set_i (ovf_set_i),
    .acc_o     (acc),
    .ovf_o     (ovf_o)
  );

  assign mode = '{frac: rd_frac_i, uns: rd_uns_i, half: rd_half_i,
                  rnd: rd_rnd_i, sat: rd_sat_i};

  acc_readout_fmt #(.ACC_W(ACC_W), .DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_fmt (
    .acc_i  (acc[rd_idx_i]),
    .mode_i (mode),
    .data_o (fmt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) rd_data_o <= fmt_data;
    end
  end
endmodule

// File: rtl/acc_readout_chk.sv
module acc_readout_chk #(
  parameter int NUM_ACC = 4,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_req_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               rd_valid_o,
  input logic               wr_req_i,
  input logic [IDX_W-1:0]   wr_idx_i,
  input logic [NUM_ACC-1:0] ovf_set_i,
  input logic [NUM_ACC-1:0] ovf_o
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o); // R2
  AST_DATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rd_data_o)); // R2
  AST_WRITE_CLEARS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> !ovf_o[$past(wr_idx_i)]); // R11
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_i |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o))); // R11
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_req_i && (ovf_set_i != '0)) |=> ((ovf_o & $past(ovf_set_i)) == $past(ovf_set_i))); // R11
endmodule

bind acc_readout acc_readout_chk #(
  .NUM_ACC(NUM_ACC), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_i   (rd_req_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .wr_req_i   (wr_req_i),
  .wr_idx_i   (wr_idx_i),
  .ovf_set_i  (ovf_set_i),
  .ovf_o      (ovf_o)
);

// File: tb/acc_readout_bench.sv
`timescale 1ns/1ps
module acc_readout_bench;
  localparam int NUM_ACC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 0, rd_frac = 0, rd_uns = 0, rd_half = 0, rd_rnd = 0, rd_sat = 0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        wr_req = 0, wr_frac = 0, wr_uns = 0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  ovf_set = '0;
  logic [3:0]  ovf;

  acc_readout u_acc_readout (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_i(rd_req), .rd_idx_i(rd_idx), .rd_frac_i(rd_frac), .rd_uns_i(rd_uns),
    .rd_half_i(rd_half), .rd_rnd_i(rd_rnd), .rd_sat_i(rd_sat),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .wr_req_i(wr_req), .wr_idx_i(wr_idx), .wr_frac_i(wr_frac), .wr_uns_i(wr_uns),
    .wr_data_i(wr_data), .ovf_set_i(ovf_set), .ovf_o(ovf)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit armed = 0;
  bit done = 0;

  longint      m_acc [NUM_ACC];
  string       w_tag [NUM_ACC];
  bit [3:0]    m_ovf;
  bit          m_valid;
  bit [31:0]   m_data;
  string       m_tag;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] ref_read(longint a, bit frac, bit uns, bit half, bit rnd, bit sat);
    longint q, r;
    if (frac && half) begin
      q = a >>> 24;
      r = a & 64'hFF_FFFF;
      if (r > 64'h80_0000) q = q + 1;
      else if (r == 64'h80_0000) q = q + (q & 1);
      if (sat && (q > 32767 || q < -32768)) return (q < 0) ? 32'h8000 : 32'h7FFF;
      return 32'(q & 64'hFFFF);
    end else if (frac) begin
      q = a >>> 8;
      r = a & 64'hFF;
      if (rnd) begin
        if (r > 64'h80) q = q + 1;
        else if (r == 64'h80) q = q + (q & 1);
      end
      if (sat && (q > 64'sd2147483647 || q < -64'sd2147483648))
        return (q < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return 32'(q);
    end else if (uns) begin
      if (a >= 0 && a < 64'sh1_0000_0000) return 32'(a);
      return 32'hFFFF_FFFF;
    end else begin
      if (a >= -64'sd2147483648 && a <= 64'sd2147483647) return 32'(a);
      return (a < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    end
  endfunction

  function automatic string read_tag(bit frac, bit uns, bit half, bit rnd, bit sat);
    if (frac && sat) return "R6";
    if (frac && half) return "R3";
    if (frac) return rnd ? "R4" : "R5";
    return uns ? "R8" : "R7";
  endfunction

  // reference model: reads see the value before any same-cycle write (R12)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ACC; i++) begin m_acc[i] = 0; w_tag[i] = "R1"; end
      m_ovf = '0; m_valid = 0; m_data = '0; m_tag = "R1";
    end else begin
      if (rd_req) begin
        m_data = ref_read(m_acc[rd_idx], rd_frac, rd_uns, rd_half, rd_rnd, rd_sat);
        m_tag  = $sformatf("%s %s%s", read_tag(rd_frac, rd_uns, rd_half, rd_rnd, rd_sat),
                           w_tag[rd_idx], (wr_req && wr_idx == rd_idx) ? " R12" : "");
      end
      m_valid = rd_req;
      m_ovf = m_ovf | ovf_set;
      if (wr_req) begin
        if (wr_frac)     begin m_acc[wr_idx] = longint'($signed(wr_data)) * 256; w_tag[wr_idx] = "R9"; end
        else if (wr_uns) begin m_acc[wr_idx] = longint'({32'h0, wr_data});       w_tag[wr_idx] = "R10"; end
        else             begin m_acc[wr_idx] = longint'($signed(wr_data));       w_tag[wr_idx] = "R10"; end
        m_ovf[wr_idx] = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R2 valid", rd_valid, m_valid);
      if (m_valid) chk(m_tag, rd_data, m_data);
      else         chk("R2 hold", rd_data, m_data);
      chk("R11 ovf", ovf, m_ovf);
    end
  end

  task automatic idle();
    rd_req = 0; wr_req = 0; ovf_set = '0;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] idx, bit frac, bit uns, logic [31:0] d);
    wr_req = 1; wr_idx = idx; wr_frac = frac; wr_uns = uns; wr_data = d;
    @(negedge clk);
    wr_req = 0;
  endtask

  task automatic rd(logic [1:0] idx, bit frac, bit uns, bit half, bit rnd, bit sat);
    rd_req = 1; rd_idx = idx; rd_frac = frac; rd_uns = uns;
    rd_half = half; rd_rnd = rnd; rd_sat = sat;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic report();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid", rd_valid, 1'b0);
    chk("R1 data", rd_data, 32'h0);
    chk("R1 ovf", ovf, 4'h0);
    armed = 1;
    for (int i = 0; i < NUM_ACC; i++) rd(2'(i), 0, 0, 0, 0, 0);
    idle();
    // R3: half-width rounding, ties to even
    wr(0, 1, 0, 32'h0001_8000); rd(0, 1, 0, 1, 0, 0);
    wr(1, 1, 0, 32'h0002_8000); rd(1, 1, 0, 1, 0, 0);
    wr(2, 1, 0, 32'h0001_8001); rd(2, 1, 0, 1, 0, 0);
    wr(3, 1, 0, 32'hFFFF_8000); rd(3, 1, 0, 1, 0, 0);
    // R4 and R5: 32-bit rounding on the guard byte
    wr(0, 0, 0, 32'h0000_0180); rd(0, 1, 0, 0, 1, 0); rd(0, 1, 0, 0, 0, 0);
    wr(0, 0, 0, 32'h0000_017F); rd(0, 1, 0, 0, 1, 0);
    wr(0, 0, 0, 32'h0000_0181); rd(0, 1, 0, 0, 1, 0);
    wr(0, 0, 0, 32'h0000_0280); rd(0, 1, 0, 0, 1, 0); rd(0, 1, 0, 0, 0, 0);
    wr(0, 0, 0, 32'hFFFF_FF80); rd(0, 1, 0, 0, 1, 1);
    // R6: 16-bit clamp versus truncation; R7 and R8 clamps
    wr(1, 1, 0, 32'h7FFF_FFFF); rd(1, 1, 0, 1, 0, 1); rd(1, 1, 0, 1, 0, 0);
    rd(1, 0, 0, 0, 0, 0); rd(1, 0, 1, 0, 0, 0);
    wr(2, 1, 0, 32'h8000_0000); rd(2, 1, 0, 1, 0, 1); rd(2, 0, 0, 0, 0, 0); rd(2, 0, 1, 0, 0, 0);
    wr(3, 0, 0, 32'hFFFF_FFFE); rd(3, 0, 0, 0, 0, 0); rd(3, 0, 1, 0, 0, 0);
    wr(3, 0, 1, 32'hFFFF_FFFE); rd(3, 0, 1, 0, 0, 0); rd(3, 0, 0, 0, 0, 0);
    // R11: sticky set, write clear, clear wins over set
    ovf_set = 4'b1010; @(negedge clk); ovf_set = '0;
    idle(); idle();
    wr(1, 0, 0, 32'h5);
    ovf_set = 4'b1000; wr_req = 1; wr_idx = 3; wr_frac = 0; wr_uns = 0; wr_data = 32'h9;
    @(negedge clk); ovf_set = '0; wr_req = 0;
    idle();
    // R12: read and write same accumulator same cycle
    rd_req = 1; rd_idx = 0; rd_frac = 0; rd_uns = 0; rd_half = 0; rd_rnd = 0; rd_sat = 0;
    wr_req = 1; wr_idx = 0; wr_frac = 0; wr_uns = 1; wr_data = 32'h1234_5678;
    @(negedge clk); rd_req = 0; wr_req = 0;
    rd(0, 0, 1, 0, 0, 0);
    idle();
    for (int k = 0; k < 600; k++) begin
      rd_req  = 1'($urandom);       rd_idx  = 2'($urandom);
      rd_frac = 1'($urandom);       rd_uns  = 1'($urandom);
      rd_half = 1'($urandom);       rd_rnd  = 1'($urandom);
      rd_sat  = 1'($urandom);
      wr_req  = 1'($urandom);       wr_idx  = 2'($urandom);
      wr_frac = 1'($urandom);       wr_uns  = 1'($urandom);
      wr_data = ($urandom % 4 == 0) ? {$urandom} | 32'h0000_8000 : $urandom;
      ovf_set = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
      @(negedge clk);
    end
    idle(); idle();
    report();
  end
endmodule